// File: doc/BRIEF.md
# I/O Register Space Access Unit

This unit sits between a CPU's load/store path and a small bank of peripheral registers. It accepts one request per cycle and decides from the operation type and address which register, if any, is the target. It then performs the read, write, single-bit edit or bit test on that register. Two address views reach the same registers. Port-style operations use a 6-bit I/O address. Load/store operations use a data-space address in which the I/O registers appear 0x20 higher. A further extended region is reachable only through load/store.

Some registers hold status flags. Peripheral event inputs set these flags, and software clears a flag by writing a one to its bit. Single-bit set and clear are carried out as read-modify-write of the whole register. A bit edit aimed at one bit of a flag register therefore also clears every other flag that reads as one. Reads and bit tests return their result one cycle after the request.

Top module: `iosp_unit`

## Requirements
- R1: Port-style operations (req_op 0 = port read, 1 = port write) address I/O locations 0x00 to 0x3F. A port-style request with req_addr above 0x3F touches no register, and a port read of it returns 0.
- R2: Load (req_op 2) and store (req_op 3) at data address A, with 0x20 <= A <= 0x5F, reach the same register as a port operation at I/O address A - 0x20.
- R3: The extended region (data addresses 0x60 and up) is reached only by load/store. A port-style access cannot reach it.
- R4: Bit set (req_op 4), bit clear (req_op 5) and bit test (req_op 6) act only on I/O addresses 0x00 to 0x1F, on the bit selected by req_bit. At any other address a bit edit changes no register and a bit test returns 0.
- R5: In a flag register, writing a one to a flag bit clears it, and writing a zero leaves it unchanged. flag_set[6k+j] sets bit j of flag register k.
- R6: A bit set or bit clear reads the whole target register, changes the one selected bit and writes the whole result back with ordinary write semantics. On a flag register this clears every flag that was set, except the target bit of a bit clear.
- R7: Reserved bits always read 0. Reads of unmapped addresses return 0, and writes to unmapped addresses change nothing.
- R8: When a flag-set event and a write-one clear of the same flag fall in the same cycle, the flag ends up set.
- R9: A bit test returns the selected bit on test_bit and leaves every register unchanged.
- R10: rsp_valid goes high exactly one cycle after each accepted port read, load or bit test. rd_data then carries the register value from the cycle of the request; rd_data is 0 for a bit test.
- R11: After reset, every register reads 0 and rsp_valid is 0.
- R12: The register map, by I/O address, is as follows:
  - 0x00 to 0x03: four read/write 8-bit registers.
  - 0x04 and 0x05: flag registers 0 and 1, with bits 5:0 implemented.
  - 0x20: a read/write register with bits 3:0 implemented.
  - Data addresses 0x60 and 0x61: two read/write 8-bit extended registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 port rd, 1 port wr, 2 load, 3 store, 4 bit set, 5 bit clear, 6 bit test, 7 none) |
| req_addr | input | 8 | I/O address for port-style operations, data address for load/store |
| req_wdata | input | 8 | Write data for port write and store |
| req_bit | input | 3 | Bit index for bit set, bit clear and bit test |
| flag_set | input | 12 | Peripheral flag-set events, six per flag register |
| rsp_valid | output | 1 | Read or test result valid |
| rd_data | output | 8 | Read result |
| test_bit | output | 1 | Bit test result |

## Verification
A wrong decode shows at the next read as data from the wrong register, or as nonzero data from an unmapped address. A read through the other address view exposes it one cycle after that read is issued. A flag that is cleared when it should be kept, or kept when it should be cleared, stays wrong until the next read of its register, so the bench reads back flag registers soon after bit edits and same-cycle set/clear collisions. Reserved-bit leakage and side effects of a bit test show on the first read after the offending request.

// File: rtl/iosp_pkg.sv
package iosp_pkg;
  localparam int DW = 8;
  localparam logic [7:0] PORT_LIMIT = 8'h40;
  localparam logic [7:0] BIT_LIMIT  = 8'h20;
  localparam logic [7:0] DATA_OFS   = 8'h20;
  localparam logic [7:0] EXT_BASE   = 8'h60;
  localparam logic [7:0] HI_IO      = 8'h20;

  typedef enum logic [2:0] {
    OP_IN   = 3'd0,
    OP_OUT  = 3'd1,
    OP_LD   = 3'd2,
    OP_ST   = 3'd3,
    OP_SETB = 3'd4,
    OP_CLRB = 3'd5,
    OP_TSTB = 3'd6,
    OP_NONE = 3'd7
  } iosp_op_e;

  function automatic logic op_is_port(iosp_op_e op);
    return (op == OP_IN) || (op == OP_OUT) || (op == OP_SETB) ||
           (op == OP_CLRB) || (op == OP_TSTB);
  endfunction

  function automatic logic op_is_bit(iosp_op_e op);
    return (op == OP_SETB) || (op == OP_CLRB) || (op == OP_TSTB);
  endfunction

  function automatic logic op_is_write(iosp_op_e op);
    return (op == OP_OUT) || (op == OP_ST) || (op == OP_SETB) || (op == OP_CLRB);
  endfunction

  function automatic logic op_is_read(iosp_op_e op);
    return (op == OP_IN) || (op == OP_LD) || (op == OP_TSTB);
  endfunction

  // Replace one bit of a register image, leaving the rest as read.
  function automatic logic [DW-1:0] bit_edit(logic [DW-1:0] cur, logic [2:0] pos, logic val);
    logic [DW-1:0] r;
    r = cur;
    r[pos] = val;
    return r;
  endfunction

  // Write-one-to-clear update; a set event in the same cycle dominates.
  function automatic logic [DW-1:0] w1c_next(logic [DW-1:0] q, logic [DW-1:0] clr,
                                             logic [DW-1:0] set);
    return (q & ~clr) | set;
  endfunction
endpackage

// File: rtl/iosp_decode.sv
module iosp_decode
  import iosp_pkg::*;
#(
  parameter int N_CTRL = 4,
  parameter int N_FLAG = 2,
  parameter int N_EXT  = 2,
  parameter int IDX_W  = 4
) (
  input  iosp_op_e         op,
  input  logic [7:0]       addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             is_flag
);
  localparam logic [7:0] CTRL_END = 8'(N_CTRL);
  localparam logic [7:0] FLAG_END = 8'(N_CTRL + N_FLAG);
  localparam logic [7:0] EXT_CNT  = 8'(N_EXT);
  localparam logic [IDX_W-1:0] HI_SLOT  = IDX_W'(N_CTRL + N_FLAG);
  localparam logic [IDX_W-1:0] EXT_SLOT = IDX_W'(N_CTRL + N_FLAG + 1);

  logic       io_hit, ext_hit, bit_gate;
  logic [7:0] ioa, eoff;

  always_comb begin
    io_hit  = 1'b0;
    ext_hit = 1'b0;
    ioa     = '0;
    eoff    = '0;
    if (op_is_port(op)) begin
      if (addr < PORT_LIMIT) begin
        io_hit = 1'b1;
        ioa    = addr;
      end
    end else if ((op == OP_LD) || (op == OP_ST)) begin
      if (addr >= EXT_BASE) begin
        ext_hit = 1'b1;
        eoff    = addr - EXT_BASE;
      end else if (addr >= DATA_OFS) begin
        io_hit = 1'b1;
        ioa    = addr - DATA_OFS;
      end
    end
  end

  assign bit_gate = !op_is_bit(op) || (ioa < BIT_LIMIT);

  always_comb begin
    hit     = 1'b0;
    idx     = '0;
    is_flag = 1'b0;
    if (io_hit && bit_gate) begin
      if (ioa < CTRL_END) begin
        hit = 1'b1;
        idx = IDX_W'(ioa);
      end else if (ioa < FLAG_END) begin
        hit     = 1'b1;
        idx     = IDX_W'(ioa);
        is_flag = 1'b1;
      end else if (ioa == HI_IO) begin
        hit = 1'b1;
        idx = HI_SLOT;
      end
    end else if (ext_hit && (eoff < EXT_CNT)) begin
      hit = 1'b1;
      idx = EXT_SLOT + IDX_W'(eoff);
    end
  end
endmodule

// File: rtl/iosp_rw_cell.sv
module iosp_rw_cell #(
  parameter logic [7:0] MASK = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wd,
  output logic [7:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wd & MASK;
  end
endmodule

// File: rtl/iosp_flag_cell.sv
module iosp_flag_cell
  import iosp_pkg::*;
#(
  parameter int FLAG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        wd,
  input  logic [FLAG_W-1:0] set,
  output logic [7:0]        q
);
  logic [FLAG_W-1:0] fq;
  logic [7:0]        clr, nxt;

  assign clr = we ? (wd & 8'((1 << FLAG_W) - 1)) : 8'h00;
  assign nxt = w1c_next(8'(fq), clr, 8'(set));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fq <= '0;
    else        fq <= nxt[FLAG_W-1:0];
  end

  assign q = 8'(fq);
endmodule

// File: rtl/iosp_regbank.sv
module iosp_regbank #(
  parameter int         N_CTRL  = 4,
  parameter int         N_FLAG  = 2,
  parameter int         N_EXT   = 2,
  parameter int         FLAG_W  = 6,
  parameter logic [7:0] HI_MASK = 8'h0F,
  parameter int         NREG    = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          we,
  input  logic [7:0]               wd,
  input  logic [N_FLAG*FLAG_W-1:0] flag_set,
  output logic [NREG*8-1:0]        q_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if ((i >= N_CTRL) && (i < N_CTRL + N_FLAG)) begin : g_flag
      iosp_flag_cell #(.FLAG_W(FLAG_W)) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we[i]),
        .wd   (wd),
        .set  (flag_set[(i-N_CTRL)*FLAG_W +: FLAG_W]),
        .q    (q_flat[i*8 +: 8])
      );
    end else begin : g_rw
      localparam logic [7:0] M = (i == N_CTRL + N_FLAG) ? HI_MASK : 8'hFF;
      iosp_rw_cell #(.MASK(M)) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we[i]),
        .wd   (wd),
        .q    (q_flat[i*8 +: 8])
      );
    end
  end
endmodule

// File: rtl/iosp_unit.sv
module iosp_unit
  import iosp_pkg::*;
#(
  parameter int         N_CTRL  = 4,
  parameter int         N_FLAG  = 2,
  parameter int         N_EXT   = 2,
  parameter int         FLAG_W  = 6,
  parameter logic [7:0] HI_MASK = 8'h0F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_op,
  input  logic [7:0]               req_addr,
  input  logic [7:0]               req_wdata,
  input  logic [2:0]               req_bit,
  input  logic [N_FLAG*FLAG_W-1:0] flag_set,
  output logic                     rsp_valid,
  output logic [7:0]               rd_data,
  output logic                     test_bit
);
  localparam int NREG  = N_CTRL + N_FLAG + 1 + N_EXT;
  localparam int IDX_W = $clog2(NREG);

  iosp_op_e         op;
  logic             dec_hit, dec_is_flag;
  logic [IDX_W-1:0] dec_idx;
  logic [NREG*8-1:0] state_flat;
  logic [N_FLAG*FLAG_W-1:0] flag_vec;
  logic [7:0]       cur, wd;
  logic [NREG-1:0]  we;
  logic             wr_fire, rd_fire;

  assign op = iosp_op_e'(req_op);

  iosp_decode #(.N_CTRL(N_CTRL), .N_FLAG(N_FLAG), .N_EXT(N_EXT), .IDX_W(IDX_W)) u_dec (
    .op     (op),
    .addr   (req_addr),
    .hit    (dec_hit),
    .idx    (dec_idx),
    .is_flag(dec_is_flag)
  );

  iosp_regbank #(.N_CTRL(N_CTRL), .N_FLAG(N_FLAG), .N_EXT(N_EXT), .FLAG_W(FLAG_W),
                 .HI_MASK(HI_MASK), .NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .wd      (wd),
    .flag_set(flag_set),
    .q_flat  (state_flat)
  );

  for (genvar k = 0; k < N_FLAG; k++) begin : g_fv
    assign flag_vec[k*FLAG_W +: FLAG_W] = state_flat[(N_CTRL+k)*8 +: FLAG_W];
  end

  assign cur = dec_hit ? state_flat[int'(dec_idx)*8 +: 8] : 8'h00;

  always_comb begin
    unique case (op)
      OP_SETB: wd = bit_edit(cur, req_bit, 1'b1);
      OP_CLRB: wd = bit_edit(cur, req_bit, 1'b0);
      default: wd = req_wdata;
    endcase
  end

  assign wr_fire = req_valid && dec_hit && op_is_write(op);
  assign rd_fire = req_valid && op_is_read(op);
  assign we      = wr_fire ? (NREG'(1) << dec_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rd_data   <= '0;
      test_bit  <= 1'b0;
    end else begin
      rsp_valid <= rd_fire;
      rd_data   <= (rd_fire && (op != OP_TSTB)) ? cur : 8'h00;
      test_bit  <= rd_fire && (op == OP_TSTB) && cur[req_bit];
    end
  end
endmodule

// File: rtl/iosp_unit_chk.sv
module iosp_unit_chk
  import iosp_pkg::*;
#(
  parameter int N_CTRL = 4,
  parameter int N_FLAG = 2,
  parameter int N_EXT  = 2,
  parameter int FLAG_W = 6,
  parameter int NREG   = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [2:0]               req_op,
  input logic [7:0]               req_addr,
  input logic [N_FLAG*FLAG_W-1:0] flag_set,
  input logic                     rsp_valid,
  input logic [7:0]               rd_data,
  input logic                     test_bit,
  input logic                     dec_hit,
  input logic                     dec_is_flag,
  input logic [NREG*8-1:0]        state_flat,
  input logic [N_FLAG*FLAG_W-1:0] flag_vec
);
  logic is_rd, is_bitop, no_events;
  assign is_rd     = (req_op == 3'd0) || (req_op == 3'd2) || (req_op == 3'd6);
  assign is_bitop  = (req_op == 3'd4) || (req_op == 3'd5) || (req_op == 3'd6);
  assign no_events = (flag_set == '0);

  p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid) && $past(is_rd)));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(dec_hit)) |-> (rd_data == 8'h00 && !test_bit));

  p_miss_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dec_hit && no_events) |=> $stable(state_flat));

  p_test_no_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd6 && no_events) |=> $stable(state_flat));

  p_bitop_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_bitop && req_addr >= 8'h20 && no_events) |=> ($stable(state_flat) && !test_bit));

  for (genvar k = 0; k < N_FLAG*FLAG_W; k++) begin : g_set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[k] |=> flag_vec[k]);
  end

  if (FLAG_W < 8) begin : g_res
    p_flag_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(dec_is_flag)) |-> (rd_data[7:FLAG_W] == '0));
  end
endmodule

bind iosp_unit iosp_unit_chk #(
  .N_CTRL(N_CTRL), .N_FLAG(N_FLAG), .N_EXT(N_EXT), .FLAG_W(FLAG_W), .NREG(NREG)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_addr   (req_addr),
  .flag_set   (flag_set),
  .rsp_valid  (rsp_valid),
  .rd_data    (rd_data),
  .test_bit   (test_bit),
  .dec_hit    (dec_hit),
  .dec_is_flag(dec_is_flag),
  .state_flat (state_flat),
  .flag_vec   (flag_vec)
);

// File: tb/iosp_unit_test.sv
module iosp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd7;
  logic [7:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [2:0]  req_bit = '0;
  logic [11:0] flag_set = '0;
  logic        rsp_valid, test_bit;
  logic [7:0]  rd_data;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] m [9];

  always #4 clk = ~clk;

  iosp_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bit(req_bit),
    .flag_set(flag_set), .rsp_valid(rsp_valid), .rd_data(rd_data), .test_bit(test_bit)
  );

  // Map a request to a model slot via a unified data-space address; -1 = no target.
  function automatic int m_slot(logic [2:0] op, logic [7:0] a);
    int da;
    bit port, bop;
    port = (op == 0) || (op == 1) || (op >= 4 && op <= 6);
    bop  = (op >= 4 && op <= 6);
    if (op == 7) return -1;
    if (port) begin
      if (a > 8'h3F) return -1;
      if (bop && a > 8'h1F) return -1;
      da = int'(a) + 32;
    end else da = int'(a);
    if (da >= 32 && da <= 37) return da - 32;
    if (da == 64) return 6;
    if (da == 96 || da == 97) return da - 89;
    return -1;
  endfunction

  function automatic logic [7:0] m_mask(int s);
    if (s == 6) return 8'h0F;
    if (s == 4 || s == 5) return 8'h3F;
    return 8'hFF;
  endfunction

  task automatic check(bit ok, string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [2:0] op, logic [7:0] a, logic [7:0] wdat, logic [2:0] bt,
                       logic [11:0] fs, string req);
    int s;
    logic [7:0] cur, w;
    logic [9:0] exp, act;
    s   = m_slot(op, a);
    cur = (s >= 0) ? m[s] : 8'h00;
    exp[9]   = (op == 0) || (op == 2) || (op == 6);
    exp[8]   = (op == 6) ? cur[bt] : 1'b0;
    exp[7:0] = (op == 0 || op == 2) ? cur : 8'h00;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wdat; req_bit = bt; flag_set = fs;
    @(negedge clk);
    act = {rsp_valid, test_bit, rd_data};
    check(act === exp, req, act, exp);
    if (s >= 0 && (op == 1 || op == 3 || op == 4 || op == 5)) begin
      w = wdat;
      if (op == 4) w = cur | (8'h01 << bt);
      if (op == 5) w = cur & ~(8'h01 << bt);
      if (s == 4 || s == 5) m[s] = m[s] & ~(w & 8'h3F);
      else                  m[s] = w & m_mask(s);
    end
    m[4] = m[4] | {2'b00, fs[5:0]};
    m[5] = m[5] | {2'b00, fs[11:6]};
    req_valid = 1'b0; req_op = 3'd7; flag_set = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [16] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h1F, 8'h20, 8'h21,
                              8'h24, 8'h25, 8'h3F, 8'h40, 8'h60, 8'h61, 8'h62, 8'h10};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 9; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R11", {9'b0, rsp_valid}, 10'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: all registers read zero after reset
    for (int a = 8'h20; a <= 8'h25; a++) do_op(3'd2, 8'(a), 8'h00, 3'd0, '0, "R11");
    do_op(3'd2, 8'h40, 8'h00, 3'd0, '0, "R11");
    do_op(3'd2, 8'h60, 8'h00, 3'd0, '0, "R11");
    // R1/R2: port write seen via data-space read and vice versa
    do_op(3'd1, 8'h02, 8'hA5, 3'd0, '0, "R1");
    do_op(3'd2, 8'h22, 8'h00, 3'd0, '0, "R2");
    do_op(3'd3, 8'h21, 8'h5A, 3'd0, '0, "R2");
    do_op(3'd0, 8'h01, 8'h00, 3'd0, '0, "R2");
    do_op(3'd1, 8'h42, 8'hFF, 3'd0, '0, "R1");
    do_op(3'd0, 8'h42, 8'h00, 3'd0, '0, "R1");
    // R7/R12: reserved bits of the upper register
    do_op(3'd3, 8'h40, 8'hFF, 3'd0, '0, "R12");
    do_op(3'd0, 8'h20, 8'h00, 3'd0, '0, "R7");
    // R3: extended region data-only
    do_op(3'd3, 8'h60, 8'h3C, 3'd0, '0, "R3");
    do_op(3'd0, 8'h60, 8'h00, 3'd0, '0, "R3");
    do_op(3'd1, 8'h60, 8'hFF, 3'd0, '0, "R3");
    do_op(3'd2, 8'h60, 8'h00, 3'd0, '0, "R3");
    // R5: write-one clear
    do_op(3'd7, 8'h00, 8'h00, 3'd0, 12'h00D, "R5");
    do_op(3'd0, 8'h04, 8'h00, 3'd0, '0, "R5");
    do_op(3'd1, 8'h04, 8'h01, 3'd0, '0, "R5");
    do_op(3'd0, 8'h04, 8'h00, 3'd0, '0, "R5");
    // R6: bit edits as whole-register read-modify-write
    do_op(3'd1, 8'h00, 8'h10, 3'd0, '0, "R6");
    do_op(3'd4, 8'h00, 8'h00, 3'd3, '0, "R6");
    do_op(3'd0, 8'h00, 8'h00, 3'd0, '0, "R6");
    do_op(3'd5, 8'h04, 8'h00, 3'd2, '0, "R6");
    do_op(3'd0, 8'h04, 8'h00, 3'd0, '0, "R6");
    // R8: set wins over same-cycle clear
    do_op(3'd1, 8'h04, 8'h04, 3'd0, 12'h004, "R8");
    do_op(3'd0, 8'h04, 8'h00, 3'd0, '0, "R8");
    // R9: bit test has no side effect
    do_op(3'd6, 8'h04, 8'h00, 3'd2, '0, "R9");
    do_op(3'd0, 8'h04, 8'h00, 3'd0, '0, "R9");
    // R4: bit ops outside 0x00-0x1F
    do_op(3'd6, 8'h20, 8'h00, 3'd0, '0, "R4");
    do_op(3'd4, 8'h20, 8'h00, 3'd7, '0, "R4");
    do_op(3'd0, 8'h20, 8'h00, 3'd0, '0, "R4");
    // R7: unmapped reads and writes
    do_op(3'd3, 8'h10, 8'hFF, 3'd0, '0, "R7");
    do_op(3'd2, 8'h10, 8'h00, 3'd0, '0, "R7");
    do_op(3'd0, 8'h3F, 8'h00, 3'd0, '0, "R7");
    // R10: no response after a write
    do_op(3'd1, 8'h03, 8'h77, 3'd0, '0, "R10");
    do_op(3'd7, 8'h00, 8'h00, 3'd0, '0, "R10");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic [7:0] a;
      logic [11:0] fs;
      op = 3'($urandom % 8);
      a  = ($urandom % 4 == 0) ? 8'($urandom) : pool[$urandom % 16];
      fs = ($urandom % 4 == 0) ? 12'($urandom) : 12'h000;
      do_op(op, a, 8'($urandom), 3'($urandom), fs, "R6_R8_rand");
    end
    // Final readback of every mapped register
    for (int a = 8'h20; a <= 8'h25; a++) do_op(3'd2, 8'(a), 8'h00, 3'd0, '0, "R2");
    do_op(3'd2, 8'h40, 8'h00, 3'd0, '0, "R12");
    do_op(3'd2, 8'h60, 8'h00, 3'd0, '0, "R3");
    do_op(3'd2, 8'h61, 8'h00, 3'd0, '0, "R3");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule